// File: doc/BRIEF.md
# Delayed Branch and Call Sequencer

This block sequences the program counter of a small controller whose control transfers use one delay slot. An instruction counts as executed in a cycle when `instr_valid` is high. With each executed instruction the block receives that instruction's decoded control operation and its operands:

- the register value to test or jump through;
- the compare immediate;
- a bit index;
- a signed relative offset;
- an absolute literal target;
- the current link register value.

A taken transfer is not applied at once. The block stores it as a pending target, executes the next instruction at PC+1, and loads the target into the PC when that next instruction completes.

Calls and returns use an internal return-address stack, kept apart from the link register. Branch-and-link does not use the stack. It hands PC+2 to the register file through a link write port. A wait operation parks the sequencer until an external resume supplies the handler address. A wait issued while a transfer is still pending is reported as a hazard.

The fetch memory, the register file and the ALU are outside this block. The instruction decoder drives the operation code and operands.

Top module: `delay_branch_seq`

## Requirements
- R1: After reset the PC is 0, no transfer is pending, the return stack is empty and the sequencer is not waiting.
- R2: An executed instruction with no transfer (op 0, or any unused code 11 to 15) advances the PC by one. A cycle with `instr_valid` low changes neither the PC nor any other state, and `next_pc` equals `pc`.
- R3: There are four conditional branches, each with target PC plus the signed offset. Op 1 is taken when the register differs from the immediate. Op 2 is taken when they are equal. Op 3 is taken when register bit `bit_sel` is 0. Op 4 is taken when that bit is 1.
- R4: After any taken transfer, the next executed instruction sits at PC+1. Once that instruction completes, the PC becomes the stored target.
- R5: A taken transfer whose target is address 0 has no effect, because a stored target of 0 means that nothing is pending.
- R6: Call (op 5) pushes PC+2 and transfers to the absolute literal. Return (op 6) transfers to the most recently pushed address and removes it. Both keep the delay slot.
- R7: The return stack holds 8 entries. A call with 8 entries present raises `stk_overflow` in that cycle, and neither pushes nor transfers. A return with no entries raises `stk_underflow` and does not transfer. In both cases the stack level stays unchanged.
- R8: Branch-and-link (op 7) raises `lr_we` in the same cycle, with `lr_wdata` equal to PC+2, and transfers to the absolute literal.
- R9: Jump-register (op 8) transfers to the low PC bits of the register value. Short return (op 9) transfers to `link_val`.
- R10: Wait (op 10) with nothing pending moves the PC to PC+1 and sets `waiting`. While waiting, instructions are ignored and the PC holds. `resume` then loads `resume_pc` and clears `waiting`. A `resume` while not waiting is ignored.
- R11: A wait issued while a transfer is pending raises `wait_hazard` in that cycle. It then acts as an ordinary instruction, so the pending target is still applied and `waiting` stays low.
- R12: A taken transfer in a delay slot is stored while the earlier target is applied. The instruction at the earlier target then forms the delay slot of the later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_op | input | 4 | Decoded control operation code |
| src_val | input | 32 | Source register value |
| cmp_imm | input | 32 | Compare immediate for ops 1 and 2 |
| bit_sel | input | 5 | Bit index for ops 3 and 4 |
| br_offset | input | 16 | Signed relative branch offset |
| abs_target | input | 16 | Absolute literal target for call and branch-and-link |
| link_val | input | 16 | Current link register value |
| resume | input | 1 | Leave the wait state |
| resume_pc | input | 16 | Address loaded on resume |
| pc | output | 16 | Address of the current instruction |
| next_pc | output | 16 | Value the PC takes at the next clock edge |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 16 | Link register write data |
| stk_overflow | output | 1 | Call refused because the stack is full |
| stk_underflow | output | 1 | Return refused because the stack is empty |
| wait_hazard | output | 1 | Wait issued while a transfer is pending |
| waiting | output | 1 | Sequencer is parked awaiting resume |

## Verification
The following outputs are combinational on the current inputs and state, so they are due in the same cycle as the instruction:

- `lr_we` and `lr_wdata`;
- the three flags;
- `next_pc`.

The bench drives each instruction just after a falling edge and reads these outputs 1 ns later. `pc` changes one rising edge after an instruction executes, and a taken target shows up in `pc` one instruction later still. The driver therefore queues the expected `pc` for that edge, and the monitor pops the queue 2 ns after each rising edge. The `waiting` output is checked at the start of the following instruction.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [3:0] {
    OP_SEQ     = 4'd0,
    OP_BR_NE   = 4'd1,
    OP_BR_EQ   = 4'd2,
    OP_BR_BCLR = 4'd3,
    OP_BR_BSET = 4'd4,
    OP_CALL    = 4'd5,
    OP_RET     = 4'd6,
    OP_BLINK   = 4'd7,
    OP_JREG    = 4'd8,
    OP_SRET    = 4'd9,
    OP_WAIT    = 4'd10
  } ctl_op_e;

  function automatic logic op_is_cond(input ctl_op_e op);
    return (op == OP_BR_NE) || (op == OP_BR_EQ) ||
           (op == OP_BR_BCLR) || (op == OP_BR_BSET);
  endfunction

endpackage

// File: rtl/dbs_rst_sync.sv
module dbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/dbs_cond.sv
module dbs_cond
  import dbs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  ctl_op_e           op,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cmp_imm,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   offset,
  output logic              taken,
  output logic [PC_W-1:0]   target
);
  logic equal_w;
  logic bit_w;

  assign equal_w = (src_val == cmp_imm);
  assign bit_w   = src_val[bit_sel];
  // Two's complement add gives the signed displacement with wrap.
  assign target  = pc + offset;

  always_comb begin
    unique case (op)
      OP_BR_NE:   taken = !equal_w;
      OP_BR_EQ:   taken = equal_w;
      OP_BR_BCLR: taken = !bit_w;
      OP_BR_BSET: taken = bit_w;
      default:    taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbs_ret_stack.sv
module dbs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] level_q, level_d;
  logic [W-1:0]     slot_q [DEPTH];

  always_comb begin
    level_d = level_q;
    if (push)     level_d = level_q + LVL_W'(1);
    else if (pop) level_d = level_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) level_q <= '0;
    else if (push || pop) level_q <= level_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (level_q == LVL_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level_q == LVL_W'(i + 1)) rdata = slot_q[i];
    end
  end

  assign level = level_q;
endmodule

// File: rtl/delay_branch_seq.sv
module delay_branch_seq
  import dbs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_W      = 16,
  parameter int STK_DEPTH = 8,
  localparam int BIT_W    = $clog2(DATA_W),
  localparam int LVL_W    = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [3:0]        instr_op,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cmp_imm,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [PC_W-1:0]   br_offset,
  input  logic [PC_W-1:0]   abs_target,
  input  logic [PC_W-1:0]   link_val,
  input  logic              resume,
  input  logic [PC_W-1:0]   resume_pc,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   next_pc,
  output logic              lr_we,
  output logic [PC_W-1:0]   lr_wdata,
  output logic              stk_overflow,
  output logic              stk_underflow,
  output logic              wait_hazard,
  output logic              waiting
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(STK_DEPTH);

  logic            rst_sn;
  ctl_op_e         op;
  logic            exec;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] pend_q, pend_d;
  logic            wait_q, wait_d;
  logic            pend_live;
  logic [PC_W-1:0] ret_addr;
  logic            cond_taken;
  logic [PC_W-1:0] cond_target;
  logic            xfer;
  logic [PC_W-1:0] xfer_tgt;
  logic            push, pop, enter_wait;
  logic            ovf, unf, haz, lrw;
  logic [PC_W-1:0] stk_top;
  logic [LVL_W-1:0] stk_level;
  logic            stk_full, stk_empty;

  dbs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign op        = ctl_op_e'(instr_op);
  assign exec      = instr_valid && !wait_q;
  assign pend_live = (pend_q != '0);
  assign ret_addr  = pc_q + PC_W'(2);
  assign stk_full  = (stk_level == FULL_LVL);
  assign stk_empty = (stk_level == '0);

  dbs_cond #(.DATA_W(DATA_W), .PC_W(PC_W)) u_cond (
    .op      (op),
    .src_val (src_val),
    .cmp_imm (cmp_imm),
    .bit_sel (bit_sel),
    .pc      (pc_q),
    .offset  (br_offset),
    .taken   (cond_taken),
    .target  (cond_target)
  );

  dbs_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk    (clk),
    .rst_sn (rst_sn),
    .push   (push),
    .pop    (pop),
    .wdata  (ret_addr),
    .rdata  (stk_top),
    .level  (stk_level)
  );

  // Decode of the transfer requested by the executing instruction.
  always_comb begin
    xfer       = 1'b0;
    xfer_tgt   = '0;
    push       = 1'b0;
    pop        = 1'b0;
    enter_wait = 1'b0;
    ovf        = 1'b0;
    unf        = 1'b0;
    haz        = 1'b0;
    lrw        = 1'b0;
    if (exec) begin
      if (op_is_cond(op)) begin
        xfer     = cond_taken;
        xfer_tgt = cond_target;
      end else begin
        unique case (op)
          OP_CALL: begin
            if (stk_full) ovf = 1'b1;
            else begin
              push     = 1'b1;
              xfer     = 1'b1;
              xfer_tgt = abs_target;
            end
          end
          OP_RET: begin
            if (stk_empty) unf = 1'b1;
            else begin
              pop      = 1'b1;
              xfer     = 1'b1;
              xfer_tgt = stk_top;
            end
          end
          OP_BLINK: begin
            lrw      = 1'b1;
            xfer     = 1'b1;
            xfer_tgt = abs_target;
          end
          OP_JREG: begin
            xfer     = 1'b1;
            xfer_tgt = src_val[PC_W-1:0];
          end
          OP_SRET: begin
            xfer     = 1'b1;
            xfer_tgt = link_val;
          end
          OP_WAIT: begin
            if (pend_live) haz = 1'b1;
            else           enter_wait = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Next-state logic for PC, pending target and wait state.
  always_comb begin
    pc_d   = pc_q;
    pend_d = pend_q;
    wait_d = wait_q;
    if (wait_q) begin
      if (resume) begin
        pc_d   = resume_pc;
        wait_d = 1'b0;
      end
    end else if (exec) begin
      pc_d   = pend_live ? pend_q : pc_q + PC_W'(1);
      pend_d = xfer ? xfer_tgt : '0;
      wait_d = enter_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pc_q   <= '0;
      pend_q <= '0;
      wait_q <= 1'b0;
    end else begin
      if (exec || wait_q) begin
        pc_q   <= pc_d;
        pend_q <= pend_d;
        wait_q <= wait_d;
      end
    end
  end

  assign pc            = pc_q;
  assign next_pc       = pc_d;
  assign lr_we         = lrw;
  assign lr_wdata      = ret_addr;
  assign stk_overflow  = ovf;
  assign stk_underflow = unf;
  assign wait_hazard   = haz;
  assign waiting       = wait_q;
endmodule

// File: rtl/delay_branch_seq_chk.sv
module delay_branch_seq_chk
  import dbs_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             instr_valid,
  input logic [3:0]       instr_op,
  input logic             resume,
  input logic             waiting,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  pend,
  input logic [LVL_W-1:0] level,
  input logic             stk_overflow,
  input logic             stk_underflow,
  input logic             lr_we
);
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !(stk_overflow && stk_underflow));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!instr_valid && !resume) |=> $stable(pc));

  assert_sequential_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (instr_valid && !waiting && pend == '0 && instr_op == 4'd0)
      |=> pc == PC_W'($past(pc) + PC_W'(1)));

  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (instr_valid && !waiting && pend != '0) |=> pc == $past(pend));

  assert_level_overflow_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    stk_overflow |=> $stable(level));

  assert_level_underflow_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    stk_underflow |=> $stable(level));

  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (waiting && !resume) |=> $stable(pc));

  assert_link_source_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    lr_we |-> (instr_valid && instr_op == 4'(OP_BLINK)));
endmodule

bind delay_branch_seq delay_branch_seq_chk #(.PC_W(PC_W), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_sn        (rst_sn),
  .instr_valid   (instr_valid),
  .instr_op      (instr_op),
  .resume        (resume),
  .waiting       (waiting),
  .pc            (pc),
  .pend          (pend_q),
  .level         (stk_level),
  .stk_overflow  (stk_overflow),
  .stk_underflow (stk_underflow),
  .lr_we         (lr_we)
);

// File: tb/test_delay_branch_seq.sv
module test_delay_branch_seq;
  import dbs_pkg::*;

  localparam int PW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          instr_valid;
  logic [3:0]    instr_op;
  logic [DW-1:0] src_val, cmp_imm;
  logic [4:0]    bit_sel;
  logic [PW-1:0] br_offset, abs_target, link_val, resume_pc;
  logic          resume;
  logic [PW-1:0] pc, next_pc, lr_wdata;
  logic          lr_we, stk_overflow, stk_underflow, wait_hazard, waiting;

  delay_branch_seq i_delay_branch_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .src_val(src_val), .cmp_imm(cmp_imm), .bit_sel(bit_sel),
    .br_offset(br_offset), .abs_target(abs_target), .link_val(link_val),
    .resume(resume), .resume_pc(resume_pc), .pc(pc), .next_pc(next_pc),
    .lr_we(lr_we), .lr_wdata(lr_wdata), .stk_overflow(stk_overflow),
    .stk_underflow(stk_underflow), .wait_hazard(wait_hazard), .waiting(waiting)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Scoreboard of expected PC values, one per rising edge.
  logic [PW-1:0] exp_q[$];
  string         req_q[$];
  logic [PW-1:0] mon_e;
  string         mon_r;

  // Model state derived from the requirements.
  logic [PW-1:0] m_pc, m_pend;
  logic [PW-1:0] m_stk [DEPTH];
  int            m_sp;
  bit            m_wait;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_r = req_q.pop_front();
      check(mon_r, "pc", 64'(pc), 64'(mon_e));
    end
  end

  task automatic step(string req, ctl_op_e op, logic [DW-1:0] src = '0,
                      logic [DW-1:0] imm = '0, logic [4:0] b = '0,
                      logic [PW-1:0] off = '0, logic [PW-1:0] tgt = '0,
                      logic [PW-1:0] lnk = '0);
    bit xf = 0, we = 0, ov = 0, un = 0, hz = 0, ent = 0;
    logic [PW-1:0] tg = '0;
    logic [PW-1:0] nx;
    logic [PW-1:0] ra;
    @(negedge clk);
    instr_valid = 1'b1; resume = 1'b0; instr_op = op; src_val = src; cmp_imm = imm;
    bit_sel = b; br_offset = off; abs_target = tgt; link_val = lnk;
    ra = m_pc + PW'(2);
    if (!m_wait) begin
      case (op)
        OP_BR_NE:   begin xf = (src != imm); tg = m_pc + off; end
        OP_BR_EQ:   begin xf = (src == imm); tg = m_pc + off; end
        OP_BR_BCLR: begin xf = !src[b];      tg = m_pc + off; end
        OP_BR_BSET: begin xf = src[b];       tg = m_pc + off; end
        OP_CALL: if (m_sp == DEPTH) ov = 1;
                 else begin m_stk[m_sp] = ra; m_sp++; xf = 1; tg = tgt; end
        OP_RET:  if (m_sp == 0) un = 1;
                 else begin m_sp--; xf = 1; tg = m_stk[m_sp]; end
        OP_BLINK: begin we = 1; xf = 1; tg = tgt; end
        OP_JREG:  begin xf = 1; tg = src[PW-1:0]; end
        OP_SRET:  begin xf = 1; tg = lnk; end
        OP_WAIT:  if (m_pend != '0) hz = 1; else ent = 1;
        default: ;
      endcase
      nx = (m_pend != '0) ? m_pend : m_pc + PW'(1);
    end else begin
      nx = m_pc;
    end
    #1;
    check(req, "waiting", 64'(waiting), 64'(m_wait));
    check(req, "flags {lr_we,ovf,unf,haz}",
          64'({lr_we, stk_overflow, stk_underflow, wait_hazard}), 64'({we, ov, un, hz}));
    if (we) check(req, "lr_wdata", 64'(lr_wdata), 64'(ra));
    check(req, "next_pc", 64'(next_pc), 64'(nx));
    if (!m_wait) begin
      m_pend = xf ? tg : '0;
      m_wait = ent;
    end
    m_pc = nx;
    exp_q.push_back(nx);
    req_q.push_back(req);
  endtask

  task automatic stall(string req);
    @(negedge clk);
    instr_valid = 1'b0; resume = 1'b0; instr_op = 4'(OP_CALL);
    #1;
    check(req, "stall next_pc", 64'(next_pc), 64'(m_pc));
    check(req, "stall flags", 64'({lr_we, stk_overflow, stk_underflow, wait_hazard}), 64'(0));
    exp_q.push_back(m_pc);
    req_q.push_back(req);
  endtask

  task automatic do_resume(string req, logic [PW-1:0] rpc);
    @(negedge clk);
    instr_valid = 1'b0; resume = 1'b1; resume_pc = rpc;
    if (m_wait) begin m_pc = rpc; m_wait = 0; end
    #1;
    check(req, "resume next_pc", 64'(next_pc), 64'(m_pc));
    exp_q.push_back(m_pc);
    req_q.push_back(req);
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; resume = 1'b0; instr_op = '0;
    src_val = '0; cmp_imm = '0; bit_sel = '0; br_offset = '0;
    abs_target = '0; link_val = '0; resume_pc = '0;
    m_pc = '0; m_pend = '0; m_sp = 0; m_wait = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset pc", 64'(pc), 64'(0));
    check("R1", "reset waiting", 64'(waiting), 64'(0));
    check("R1", "reset next_pc idle", 64'(next_pc), 64'(0));

    // R7 underflow straight after reset (R1 empty stack)
    step("R7", OP_RET);
    step("R2", OP_SEQ);
    step("R2", OP_SEQ);
    step("R2", ctl_op_e'(4'd13));
    stall("R2");
    stall("R2");

    // R3 conditional branches with R4 delay slots
    step("R3", OP_BR_NE, 32'd5, 32'd3, 5'd0, 16'd10);
    step("R4", OP_SEQ);
    step("R3", OP_BR_NE, 32'd7, 32'd7, 5'd0, 16'd40);
    step("R3", OP_BR_EQ, 32'h1234, 32'h1234, 5'd0, 16'hFFFC);
    step("R4", OP_SEQ);
    step("R3", OP_BR_BCLR, 32'hFFFF_FF7F, 32'd0, 5'd7, 16'd6);
    step("R4", OP_SEQ);
    step("R3", OP_BR_BCLR, 32'h0000_0080, 32'd0, 5'd7, 16'd6);
    step("R3", OP_BR_BSET, 32'h8000_0000, 32'd0, 5'd31, 16'h0100);
    stall("R4");
    step("R4", OP_SEQ);
    step("R3", OP_BR_BSET, 32'h7FFF_FFFF, 32'd0, 5'd31, 16'h0100);

    // R5 taken branch whose target is 0
    step("R5", OP_BR_EQ, 32'd1, 32'd1, 5'd0, 16'(0) - m_pc);
    step("R5", OP_SEQ);
    step("R5", OP_SEQ);

    // R12 transfer in a delay slot
    step("R12", OP_BR_EQ, 32'd0, 32'd0, 5'd0, 16'd20);
    step("R12", OP_JREG, 32'h0000_0300);
    step("R12", OP_SEQ);
    step("R12", OP_SEQ);

    // R6 nested calls up to full depth, then R7 overflow
    for (int i = 0; i < DEPTH; i++) begin
      step("R6", OP_CALL, '0, '0, '0, '0, 16'(16'h1000 + i * 16'h10));
      step("R6", OP_SEQ);
    end
    step("R7", OP_CALL, '0, '0, '0, '0, 16'h2000);
    step("R7", OP_SEQ);
    for (int i = 0; i < DEPTH; i++) begin
      step("R6", OP_RET);
      step("R6", OP_SEQ);
    end
    step("R7", OP_RET);
    step("R7", OP_SEQ);

    // R8 branch-and-link, R9 short return and jump-register
    step("R8", OP_BLINK, '0, '0, '0, '0, 16'h0500);
    step("R8", OP_SEQ);
    step("R9", OP_SRET, '0, '0, '0, '0, '0, 16'h0042);
    step("R9", OP_SEQ);
    step("R9", OP_JREG, 32'hABCD_0600);
    step("R9", OP_SEQ);
    step("R9", OP_SEQ);

    // R10 wait, ignored instructions, resume
    step("R10", OP_WAIT);
    step("R10", OP_BR_EQ, 32'd0, 32'd0, 5'd0, 16'd50);
    stall("R10");
    step("R10", OP_CALL, '0, '0, '0, '0, 16'h0900);
    do_resume("R10", 16'h0400);
    step("R10", OP_SEQ);
    do_resume("R10", 16'h0777);
    step("R10", OP_SEQ);

    // R11 wait in a delay slot
    step("R11", OP_BR_NE, 32'd1, 32'd0, 5'd0, 16'd8);
    step("R11", OP_WAIT);
    step("R11", OP_SEQ);
    step("R11", OP_SEQ);

    @(negedge clk);
    instr_valid = 1'b0; resume = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule